// File: doc/BRIEF.md
# MDIO management frame master

This block is the master side of a two-wire PHY management link. It builds clause 22 management frames on a clock line (MDC) and a bidirectional data line (MDIO) so that a host can read and write registers in an external PHY. The host raises `req_valid` for one cycle with a PHY address, a register address, the direction and, for a write, 16 bits of data. The block then shifts the frame out and shows `busy` while it does so. At the end it pulses `done` and presents the read data and an error flag. The MDIO pad itself lives outside the block. The block drives `mdio_o` and the output enable `mdio_oe`, and it reads the pad through `mdio_i`.

MDC comes from a divider of the system clock. The parameter `HALF_SLOW` is the number of system clocks in each half MDC period at the standard rate; for example, 20 at 100 MHz gives 2.5 MHz. Setting `fast_mdc` with a request halves the half-period for that frame. The block changes MDIO as MDC falls and samples it as MDC rises.

The block learns when it may leave out the 32-bit preamble. A clean read of the PHY status register (address 1) with the suppression-capability bit (bit 6) set turns the preamble off for later frames. A reset, any read that fails the turnaround check, or a pulse on `phy_detach` turns it back on.

The sequencer has six states:
- IDLE: lines quiet.
- PREAMBLE: 32 ones.
- COMMAND: start, opcode, PHY address and register address, 14 bits.
- TURN: turnaround, 2 bits.
- PAYLOAD: data, 16 bits.
- RELEASE: one idle bit with MDIO released.

Its transitions are:
- IDLE to PREAMBLE on an accepted request while suppression is off.
- IDLE to COMMAND on an accepted request while suppression is on.
- PREAMBLE to COMMAND, COMMAND to TURN, TURN to PAYLOAD and PAYLOAD to RELEASE, each on the MDC fall that ends the last bit of the field.
- RELEASE to IDLE on the MDC fall that ends the idle bit. `done` follows in the next cycle.

Top module: `mdio_master`

## Requirements
- R1: A write frame is sent on MDC rising edges in this order: 32 preamble ones, start code 01, opcode 01, the 5-bit PHY address MSB first, the 5-bit register address MSB first, turnaround driven as 1 then 0, and the 16 data bits MSB first. After that comes one idle MDC cycle with `mdio_oe` low, for 65 MDC cycles in all.
- R2: A read frame carries opcode 10. `mdio_oe` is low for both turnaround cycles, the 16 data cycles and the idle cycle. The bits sampled on the 16 data rising edges, MSB first, appear on `rd_data` when `done` pulses.
- R3: On a read, if `mdio_i` is not 0 at the rising edge of the second turnaround cycle, `rd_err` is 1 while `done` pulses. Otherwise, and on every write, `rd_err` is 0.
- R4: After a read of register address 1 that ends without a read error and returns bit 6 set, later frames omit the preamble and take 33 MDC cycles.
- R5: Preamble suppression is cancelled by a reset, by any read that ends with a read error, or by a one-cycle pulse on `phy_detach`. The next frame then takes 65 MDC cycles again.
- R6: At the standard rate each MDC half period is `HALF_SLOW` system clocks. When `fast_mdc` is 1 at acceptance it is `HALF_SLOW/2` system clocks for that whole frame.
- R7: While no frame is active, `mdc` is 0 and `mdio_oe` is 0.
- R8: `busy` is 1 from the cycle after an accepted request until `done`. `done` is a one-cycle pulse during which `busy` is already 0. `mdio_o` and `mdio_oe` do not change while MDC stays high.
- R9: A request arriving while `busy` is 1 is ignored. The frame in flight is unchanged and only one `done` is produced.
- R10: A request with PHY address 29, 30 or 31 is ignored. `busy` stays 0 and no MDC edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Data for a write |
| fast_mdc | input | 1 | Selects the doubled MDC rate for this request |
| phy_detach | input | 1 | Pulse signalling that the PHY was disconnected |
| mdio_i | input | 1 | MDIO value read from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable, 0 means released |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data captured by the last read |
| rd_err | output | 1 | Turnaround check failed on the last read |

## Verification
A wrong state or a wrong bit counter shows up at the pins in the same frame. Such a fault adds or removes MDC cycles, or drives MDIO in a window where it should be released. The bench therefore compares every sampled bit and the MDC count of every frame as soon as `done` arrives. A stale preamble-suppression flag gives no wrong bit in the frame where it goes wrong. It shows only in the length of the next frame, 33 versus 65 cycles, so every learn and cancel event is followed by a frame whose length is checked. A divider fault shows up in the spacing of the first two MDC rises of a frame, which is measured at both rates.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_COMMAND,
        ST_TURN,
        ST_PAYLOAD,
        ST_RELEASE
    } mfm_state_e;

    localparam logic [1:0] START_CODE   = 2'b01;
    localparam logic [1:0] OPC_READ     = 2'b10;
    localparam logic [1:0] OPC_WRITE    = 2'b01;
    localparam logic [1:0] TURN_WRITE   = 2'b10;
    localparam logic [1:0] TURN_READ    = 2'b00;

    localparam int PRE_BITS  = 32;
    localparam int CMD_BITS  = 14;
    localparam int TURN_BITS = 2;
    localparam int DATA_BITS = 16;
    localparam int SHIFT_W   = CMD_BITS + TURN_BITS + DATA_BITS;

    localparam logic [4:0] STATUS_REG_ADDR    = 5'd1;
    localparam logic [4:0] FIRST_RESERVED_PHY = 5'd29;
    localparam int         ABILITY_BIT        = 6;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_SLOW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF_FAST = (HALF_SLOW / 2 < 1) ? 1 : HALF_SLOW / 2;
    localparam int CNT_W     = $clog2(HALF_SLOW + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             tick;

    assign limit     = fast ? CNT_W'(HALF_FAST - 1) : CNT_W'(HALF_SLOW - 1);
    assign tick      = run && (cnt == limit);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_presup_track.sv
module mdio_presup_track (
    input  logic clk,
    input  logic rst_n,
    input  logic detach,
    input  logic fin,
    input  logic fin_read,
    input  logic fin_turn_ok,
    input  logic fin_ability,
    output logic suppress
);
    always_ff @(posedge clk) begin
        if (!rst_n || detach) begin
            suppress <= 1'b0;
        end else if (fin && fin_read) begin
            if (!fin_turn_ok) begin
                suppress <= 1'b0;
            end else if (fin_ability) begin
                suppress <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_master_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        fast_sel,
    input  logic        suppress,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        run,
    output logic        fast_q,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_err,
    output logic        fin,
    output logic        fin_read,
    output logic        fin_turn_ok,
    output logic        fin_ability
);
    localparam logic [4:0] PRE_LAST  = 5'(PRE_BITS - 1);
    localparam logic [4:0] CMD_LAST  = 5'(CMD_BITS - 1);
    localparam logic [4:0] TURN_LAST = 5'(TURN_BITS - 1);
    localparam logic [4:0] DATA_LAST = 5'(DATA_BITS - 1);

    mfm_state_e         state, nxt;
    logic [SHIFT_W-1:0] tx;
    logic [15:0]        rx;
    logic [4:0]         bit_cnt;
    logic [4:0]         reg_q;
    logic               wr_q;
    logic               turn_ok;
    logic               accept;
    logic               last_bit;

    assign accept   = (state == ST_IDLE) && req_valid && (req_phy < FIRST_RESERVED_PHY);
    assign last_bit = (bit_cnt == 5'd0);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (accept) nxt = suppress ? ST_COMMAND : ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && last_bit) nxt = ST_COMMAND;
            ST_COMMAND:  if (fall_tick && last_bit) nxt = ST_TURN;
            ST_TURN:     if (fall_tick && last_bit) nxt = ST_PAYLOAD;
            ST_PAYLOAD:  if (fall_tick && last_bit) nxt = ST_RELEASE;
            ST_RELEASE:  if (fall_tick) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx      <= '0;
            rx      <= '0;
            bit_cnt <= '0;
            reg_q   <= '0;
            wr_q    <= 1'b0;
            fast_q  <= 1'b0;
            turn_ok <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else begin
            done <= fin;
            if (accept) begin
                tx      <= {START_CODE, req_write ? OPC_WRITE : OPC_READ, req_phy, req_reg,
                            req_write ? TURN_WRITE : TURN_READ, req_wdata};
                rx      <= '0;
                reg_q   <= req_reg;
                wr_q    <= req_write;
                fast_q  <= fast_sel;
                turn_ok <= 1'b0;
                bit_cnt <= suppress ? CMD_LAST : PRE_LAST;
            end
            if (fall_tick) begin
                if (state inside {ST_COMMAND, ST_TURN, ST_PAYLOAD}) begin
                    tx <= tx << 1;
                end
                if (!last_bit) begin
                    bit_cnt <= bit_cnt - 1'b1;
                end else begin
                    unique case (state)
                        ST_PREAMBLE: bit_cnt <= CMD_LAST;
                        ST_COMMAND:  bit_cnt <= TURN_LAST;
                        ST_TURN:     bit_cnt <= DATA_LAST;
                        default:     bit_cnt <= '0;
                    endcase
                end
            end
            if (rise_tick) begin
                if (state == ST_TURN && last_bit) begin
                    turn_ok <= !mdio_i;
                end
                if (state == ST_PAYLOAD) begin
                    rx <= {rx[14:0], mdio_i};
                end
            end
            if (fin) begin
                rd_data <= rx;
                rd_err  <= !wr_q && !turn_ok;
            end
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        run         = busy;
        fin         = (state == ST_RELEASE) && fall_tick;
        fin_read    = !wr_q;
        fin_turn_ok = turn_ok;
        fin_ability = (reg_q == STATUS_REG_ADDR) && rx[ABILITY_BIT];
        unique case (state)
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_COMMAND: begin
                mdio_o  = tx[SHIFT_W-1];
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_PAYLOAD: begin
                mdio_o  = tx[SHIFT_W-1];
                mdio_oe = wr_q;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_SLOW = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        fast_mdc,
    input  logic        phy_detach,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_err
);
    logic run, fast_q, rise_tick, fall_tick, suppress;
    logic fin, fin_read, fin_turn_ok, fin_ability;

    mdio_mdc_gen #(.HALF_SLOW(HALF_SLOW)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(run), .fast(fast_q),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_presup_track u_presup (
        .clk(clk), .rst_n(rst_n), .detach(phy_detach), .fin(fin),
        .fin_read(fin_read), .fin_turn_ok(fin_turn_ok),
        .fin_ability(fin_ability), .suppress(suppress)
    );

    mdio_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .fast_sel(fast_mdc), .suppress(suppress), .rise_tick(rise_tick),
        .fall_tick(fall_tick), .mdio_i(mdio_i), .run(run), .fast_q(fast_q),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done),
        .rd_data(rd_data), .rd_err(rd_err), .fin(fin), .fin_read(fin_read),
        .fin_turn_ok(fin_turn_ok), .fin_ability(fin_ability)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [4:0] req_phy,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       busy,
    input logic       done,
    input logic       rd_err
);
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_phy < 5'd29) |=> busy);

    p_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_reserved_phy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_phy >= 5'd29) |=> !busy);

    p_err_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err) |-> done);
endmodule

bind mdio_master mdio_master_chk u_mdio_master_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phy(req_phy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
    .done(done), .rd_err(rd_err)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        fast_mdc = 1'b0;
    logic        phy_detach = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe, busy, done, rd_err;
    logic [15:0] rd_data;

    mdio_master #(.HALF_SLOW(HALF)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .fast_mdc(fast_mdc), .phy_detach(phy_detach), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
        .done(done), .rd_data(rd_data), .rd_err(rd_err)
    );

    always #5 clk = !clk;

    int   checks = 0;
    int   errors = 0;
    int   rises = 0;
    int   base = 0;
    int   dones = 0;
    int   pre_now = 32;
    time  t1 = 0, t2 = 0;
    logic exp_sup = 1'b0;
    logic [15:0] resp = '0;
    logic ta2 = 1'b0;
    logic cap_oe [0:79];
    logic cap_o  [0:79];

    function automatic logic phy_bit(input int rel);
        int k;
        k = rel - pre_now;
        if (k == 15) return ta2;
        if (k >= 16 && k < 32) return resp[31-k];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        int rel;
        rel = rises - base;
        if (rel >= 0 && rel < 80) begin
            cap_oe[rel] = mdio_oe;
            cap_o[rel]  = mdio_o;
        end
        if (rel == 1) t1 = $time;
        if (rel == 2) t2 = $time;
        rises = rises + 1;
    end

    always @(negedge mdc) begin
        mdio_i = phy_bit(rises - base);
    end

    always @(posedge clk) if (done) dones = dones + 1;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input bit fast,
                             input logic [15:0] rsp, input bit ta2v, input bit poke);
        int n, mism, d0, k, per;
        logic eoe, eo;
        logic [13:0] hdr;
        pre_now = exp_sup ? 0 : 32;
        resp = rsp;
        ta2 = ta2v;
        base = rises;
        d0 = dones;
        hdr = {2'b01, wr ? 2'b01 : 2'b10, phy, rg};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg;
        req_wdata = wd; fast_mdc = fast;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R8 busy after accept", busy, 1);
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            if (poke && n == 40) begin
                req_valid = 1'b1; req_write = !wr; req_phy = phy ^ 5'h3;
                req_reg = rg ^ 5'h1F; req_wdata = ~wd; fast_mdc = !fast;
            end
            if (poke && n == 41) req_valid = 1'b0;
        end
        chk(done === 1'b1, "R8 done seen", done, 1);
        chk(busy === 1'b0, "R8 busy low during done", busy, 0);
        chk(rises - base == pre_now + 33, "R1 R4 R5 MDC cycles per frame",
            rises - base, pre_now + 33);
        mism = 0;
        for (int i = 0; i < pre_now + 33; i++) begin
            k = i - pre_now;
            if (k < 0) begin eoe = 1'b1; eo = 1'b1; end
            else if (k < 14) begin eoe = 1'b1; eo = hdr[13-k]; end
            else if (k < 16) begin eoe = wr; eo = (k == 14); end
            else if (k < 32) begin eoe = wr; eo = wd[31-k]; end
            else begin eoe = 1'b0; eo = 1'b0; end
            if (cap_oe[i] !== eoe || (eoe && cap_o[i] !== eo)) mism++;
        end
        chk(mism == 0, wr ? "R1 write bit pattern" : "R2 read bit pattern", mism, 0);
        per = (fast ? HALF / 2 : HALF) * 2 * 10;
        chk(int'(t2 - t1) == per, "R6 MDC period", int'(t2 - t1), per);
        if (!wr) begin
            chk(rd_err === ta2v, "R3 read error flag", rd_err, ta2v);
            if (!ta2v) chk(rd_data === rsp, "R2 read data", rd_data, rsp);
        end else begin
            chk(rd_err === 1'b0, "R3 no error on write", rd_err, 0);
        end
        repeat (6) @(negedge clk);
        chk(dones - d0 == 1, "R9 one done per frame", dones - d0, 1);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R7 lines quiet after frame",
            {mdc, mdio_oe}, 0);
        if (!wr) begin
            if (ta2v) exp_sup = 1'b0;
            else if (rg == 5'd1 && rsp[6]) exp_sup = 1'b1;
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_sup = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R7 reset lines", {mdc, mdio_oe}, 0);
        chk(busy === 1'b0 && done === 1'b0, "R8 reset busy/done", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R6: write sweep over every usable PHY address, both rates
        for (int p = 0; p < 29; p++) begin
            run_frame(1'b1, 5'(p), 5'((p * 7) % 32), 16'(p * 16'h0913) ^ 16'hA5C3,
                      p[0], 16'h0, 1'b0, 1'b0);
        end

        // R2: reads with several data patterns
        run_frame(1'b0, 5'd3, 5'd2, 16'h0, 1'b0, 16'h1234, 1'b0, 1'b0);
        run_frame(1'b0, 5'd17, 5'd3, 16'h0, 1'b1, 16'hFFFF, 1'b0, 1'b0);
        run_frame(1'b0, 5'd0, 5'd31, 16'h0, 1'b0, 16'h8001, 1'b0, 1'b0);

        // R4: status read without the ability bit keeps the preamble
        run_frame(1'b0, 5'd4, 5'd1, 16'h0, 1'b0, 16'hFFBF, 1'b0, 1'b0);
        run_frame(1'b1, 5'd4, 5'd9, 16'h5A5A, 1'b0, 16'h0, 1'b0, 1'b0);
        // R4: ability bit set turns suppression on
        run_frame(1'b0, 5'd4, 5'd1, 16'h0, 1'b0, 16'h0040, 1'b0, 1'b0);
        run_frame(1'b1, 5'd4, 5'd9, 16'hC3C3, 1'b1, 16'h0, 1'b0, 1'b0);
        run_frame(1'b0, 5'd4, 5'd5, 16'h0, 1'b0, 16'h2468, 1'b0, 1'b0);

        // R3 R5: read error while suppressed, preamble returns
        run_frame(1'b0, 5'd4, 5'd5, 16'h0, 1'b0, 16'h1111, 1'b1, 1'b0);
        run_frame(1'b1, 5'd4, 5'd6, 16'h0F0F, 1'b0, 16'h0, 1'b0, 1'b0);

        // R5: disconnect pulse cancels suppression
        run_frame(1'b0, 5'd8, 5'd1, 16'h0, 1'b0, 16'h7849, 1'b0, 1'b0);
        @(negedge clk); phy_detach = 1'b1;
        @(negedge clk); phy_detach = 1'b0; exp_sup = 1'b0;
        run_frame(1'b1, 5'd8, 5'd0, 16'h1357, 1'b0, 16'h0, 1'b0, 1'b0);

        // R5: reset cancels suppression
        run_frame(1'b0, 5'd8, 5'd1, 16'h0, 1'b1, 16'h0040, 1'b0, 1'b0);
        pulse_reset();
        run_frame(1'b0, 5'd8, 5'd12, 16'h0, 1'b0, 16'hBEEF, 1'b0, 1'b0);

        // R9: request during a frame is ignored
        run_frame(1'b1, 5'd21, 5'd14, 16'h6A95, 1'b0, 16'h0, 1'b0, 1'b1);
        run_frame(1'b0, 5'd22, 5'd15, 16'h0, 1'b0, 16'h3C5A, 1'b0, 1'b1);

        // R10: reserved PHY addresses rejected
        for (int p = 29; p < 32; p++) begin
            base = rises;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_phy = 5'(p);
            @(negedge clk);
            req_valid = 1'b0;
            repeat (20) @(negedge clk);
            chk(busy === 1'b0 && rises == base, "R10 reserved PHY ignored",
                rises - base, 0);
        end

        finish_run();
    end
endmodule